// File: doc/BRIEF.md
# Asynchronously Loadable Binary Up Counter

This block is a synchronous binary up counter whose state can be overwritten at any moment, with no clock edge needed. Each state flip-flop has an asynchronous set and an asynchronous reset. A small decode stage drives them from a level-sensitive load request and a preset word. While the load request is high, the counter output copies the preset word within the same timestep and keeps following it if the word changes. Clock edges have no effect during that time.

An active-low clear forces the state to zero at once. The clear also blocks the set path, so no flip-flop ever sees set and reset together. After clear and load are both released, the counter counts upward on each rising clock edge from whatever value it holds. Counting uses per-bit toggle logic: a bit toggles when every bit below it is 1, and bit 0 toggles on every edge.

Top module: `aload_upcounter`

## Requirements
- R1: While `clr_n` is 0, `q` is 0 without waiting for a clock edge, and rising edges do not change it.
- R2: Clear has priority over load. With `clr_n` at 0 and `aload` at 1, `q` is 0 whatever the value of `pval`.
- R3: When `aload` rises with `clr_n` at 1, `q` equals `pval` in the same timestep, before any clock edge.
- R4: While `aload` is 1 and `clr_n` is 1, rising clock edges leave `q` equal to `pval`, and `q` follows any change of `pval` without a clock edge.
- R5: With `aload` at 0 and `clr_n` at 1, each rising edge adds 1 to `q` modulo 2^WIDTH, so all ones wraps to zero. Bit i toggles exactly when bits 0 to i-1 are all 1.
- R6: After `aload` falls, the first rising edge gives the loaded value plus 1, and counting carries on from there.
- R7: Releasing `clr_n` or `aload` does not change `q` by itself. `q` next changes on the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low, overrides load |
| aload | input | 1 | Level-sensitive asynchronous load request, active high |
| pval | input | WIDTH | Preset word copied into the state while loading |
| q | output | WIDTH | Counter state |

## Verification
The clocked properties sample at rising edges. They therefore assume that `clr_n`, `aload` and `pval` never change at a rising edge and that a load request is never pulsed between two edges. The stimulus changes every input only at falling edges, so each control level is seen consistently at the next rising edge. The same-timestep response of the load and the clear is checked by the stimulus a fraction of a cycle after each change, where no property can see it. The sweep covers every preset value of the 4-bit configuration, including the wrap from all ones.

// File: rtl/aload_cnt_pkg.sv
package aload_cnt_pkg;

    localparam int unsigned DEF_WIDTH = 4;

    // asynchronous controls for one state bit, both active low
    typedef struct packed {
        logic set_n;
        logic rst_n;
    } bit_async_t;

endpackage

// File: rtl/aload_async_ctl.sv
module aload_async_ctl
    import aload_cnt_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clr_n,
    input  logic             aload,
    input  logic [WIDTH-1:0] pval,
    output logic [WIDTH-1:0] set_n,
    output logic [WIDTH-1:0] rst_n
);

    bit_async_t ctl_d [WIDTH];

    // clear masks the set path and asserts every reset; load picks set or reset per bit
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            ctl_d[i].set_n = ~(clr_n & aload & pval[i]);
            ctl_d[i].rst_n = clr_n & ~(aload & ~pval[i]);
        end
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            set_n[i] = ctl_d[i].set_n;
            rst_n[i] = ctl_d[i].rst_n;
        end
    end

endmodule

// File: rtl/aload_toggle_chain.sv
module aload_toggle_chain
    import aload_cnt_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] tog
);

    logic [WIDTH-1:0] all_low_ones;

    assign all_low_ones[0] = 1'b1;

    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_chain
            assign all_low_ones[i] = all_low_ones[i-1] & cur[i-1];
        end
    endgenerate

    assign tog = all_low_ones;

endmodule

// File: rtl/aload_state_bit.sv
module aload_state_bit (
    input  logic clk,
    input  logic set_n,
    input  logic rst_n,
    input  logic tog,
    output logic val
);

    logic val_d;
    logic val_q;

    always_comb begin
        val_d = val_q ^ tog;
    end

    always_ff @(posedge clk or negedge rst_n or negedge set_n) begin
        if (!rst_n) begin
            val_q <= 1'b0;
        end else if (!set_n) begin
            val_q <= 1'b1;
        end else begin
            val_q <= val_d;
        end
    end

    assign val = val_q;

endmodule

// File: rtl/aload_upcounter.sv
module aload_upcounter
    import aload_cnt_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             aload,
    input  logic [WIDTH-1:0] pval,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] set_n;
    logic [WIDTH-1:0] rst_n;
    logic [WIDTH-1:0] tog;
    logic [WIDTH-1:0] cnt_q;

    aload_async_ctl #(.WIDTH(WIDTH)) u_ctl (
        .clr_n (clr_n),
        .aload (aload),
        .pval  (pval),
        .set_n (set_n),
        .rst_n (rst_n)
    );

    aload_toggle_chain #(.WIDTH(WIDTH)) u_chain (
        .cur (cnt_q),
        .tog (tog)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            aload_state_bit u_bit (
                .clk   (clk),
                .set_n (set_n[i]),
                .rst_n (rst_n[i]),
                .tog   (tog[i]),
                .val   (cnt_q[i])
            );
        end
    endgenerate

    assign q = cnt_q;

endmodule

// File: rtl/aload_upcounter_chk.sv
module aload_upcounter_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             aload,
    input logic [WIDTH-1:0] pval,
    input logic [WIDTH-1:0] q,
    input logic [WIDTH-1:0] set_n
);

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        !clr_n |-> (q == '0));  // R1

    AST_CLEAR_BLOCKS_SET: assert property (@(posedge clk)
        !clr_n |-> (set_n == '1));  // R2

    AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!clr_n)
        aload |-> (q == pval));  // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (!aload && !$past(aload) && $past(clr_n)) |-> (q == $past(q) + 1'b1));  // R5

endmodule

bind aload_upcounter aload_upcounter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .clr_n (clr_n),
    .aload (aload),
    .pval  (pval),
    .q     (q),
    .set_n (set_n)
);

// File: tb/aload_upcounter_bench.sv
`timescale 1ns/1ps
module aload_upcounter_bench;

    localparam int unsigned W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         aload = 1'b0;
    logic [W-1:0] pval = '0;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    aload_upcounter #(.WIDTH(W)) u_aload_upcounter (
        .clk   (clk),
        .clr_n (clr_n),
        .aload (aload),
        .pval  (pval),
        .q     (q)
    );

    task automatic expect_q(input logic [W-1:0] exp, input string req);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s q=%0h expected=%0h at %0t", req, q, exp, $time);
        end
    endtask

    initial begin
        #1 clr_n = 1'b0;
        #0.5 expect_q('0, "R1 reset state");
        for (int p = 0; p < (1 << W); p++) begin
            logic [W-1:0] exp;
            // clear with load and preset present: clear wins
            @(negedge clk);
            clr_n = 1'b0; aload = 1'b1; pval = W'(p);
            #0.5 expect_q('0, "R2 clear over load");
            @(negedge clk);
            expect_q('0, "R1 clear holds over edge");
            // leave clear, no load: value stays until edge
            aload = 1'b0; clr_n = 1'b1;
            #0.5 expect_q('0, "R7 clear release");
            @(negedge clk);
            expect_q(W'(1), "R7 first count after clear");
            // raise load between edges
            aload = 1'b1;
            #0.5 expect_q(W'(p), "R3 immediate load");
            for (int e = 0; e < 2; e++) begin
                @(negedge clk);
                expect_q(W'(p), "R4 held across edge");
            end
            pval = W'(p) ^ W'(5);
            #0.5 expect_q(W'(p) ^ W'(5), "R4 tracks preset");
            pval = W'(p);
            #0.5 expect_q(W'(p), "R4 tracks preset back");
            @(negedge clk);
            aload = 1'b0;
            #0.5 expect_q(W'(p), "R7 load release");
            exp = W'(p);
            @(negedge clk);
            exp = exp + 1'b1;
            expect_q(exp, "R6 resume from loaded value");
            for (int e = 0; e < 17; e++) begin
                @(negedge clk);
                exp = exp + 1'b1;
                expect_q(exp, "R5 increment");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule